// File: doc/BRIEF.md
# Burst Mirroring Copy Engine

This block copies a programmable run of 32-bit words out of a one-time-programmable array and into system RAM over a bus master port. Its main use is at power-up or wake-up. The power controller raises a copy request, and the engine copies the array contents, starting at array word 0, into RAM. Once the last word has been written, it answers with an acknowledge.

Two configuration inputs set up each copy. The first is the bus byte address of the first destination word. The second is the word count minus one, so a value of 0 copies a single word. The array is read in bursts of up to four words, and the array returns each word one cycle after it is addressed. The words land in an eight-entry FIFO. The engine drains the FIFO as single write beats on a request/ready bus port. A burst starts only when the FIFO, counting reads already in flight, has room for a full burst. The final burst is shortened to the words that remain.

Top module: `mirror_dma`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `busy`, `copyAck`, `busReq` and `arrRdEn` are all 0.
- R2: When `copyReq` is 1 in a clock cycle while the engine is idle, `busy` is 1 from the next cycle on, and `copyAck` stays 0.
- R3: One copy performs exactly `cfgWordsM1 + 1` accepted write beats, where a beat is a cycle with `busReq` and `busReady` both 1. A value of 0 gives exactly one beat.
- R4: Write beat k carries `busAddr = cfgStartAddr + 4*k` and `busWData` equal to array word k. Array read k presents `arrAddr = k`. The array delivers its data on `arrRdData` one cycle after the `arrRdEn` cycle.
- R5: Array reads are issued in bursts of at most four consecutive `arrRdEn` cycles. Reads issued minus beats accepted never exceeds eight, so the FIFO never overflows.
- R6: While `busReady` is held at 0, the engine issues exactly min(N, 8) array reads and then stops, where N is the word count.
- R7: Exactly N array reads are issued per copy; when fewer than four words remain, the last burst is shortened and no read beyond word N-1 occurs.
- R8: In the cycle after the last write beat is accepted, `busy` is 0 and `copyAck` is 1.
- R9: `copyAck` stays 1 for as long as `copyReq` stays 1, and no new copy starts during that time. One cycle after `copyReq` drops, `copyAck` is 0 and the engine is idle. Outside a copy, `busReq` and `arrRdEn` are 0.
- R10: While `busReq` is 1 and `busReady` is 0, `busReq`, `busAddr` and `busWData` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| copyReq | input | 1 | Copy request from the power controller |
| copyAck | output | 1 | Copy done acknowledge, held until the request drops |
| busy | output | 1 | High from the accepted request to the last write beat |
| cfgStartAddr | input | ADDR_W | Bus byte address of the first destination word |
| cfgWordsM1 | input | CNT_W | Number of words to copy minus one |
| arrRdEn | output | 1 | Array read strobe |
| arrAddr | output | ARR_AW | Array word address |
| arrRdData | input | DATA_W | Array read data, valid one cycle after arrRdEn |
| busReq | output | 1 | Write beat request |
| busAddr | output | ADDR_W | Write beat byte address |
| busWData | output | DATA_W | Write beat data |
| busReady | input | 1 | Bus accepts the beat in this cycle |

## Verification
The hardest case to reach from the ports is a full FIFO with a second burst already committed: the gate on burst starts is only exercised when writes back up. The bench therefore holds `busReady` low for forty cycles at the start of one long copy and one short copy. It then counts the reads issued against min(N, 8). After the stall, an irregular ready pattern from a shift register exercises pops and bursts landing in the same cycle. The occupancy bound is checked on every clock. A request held high after completion checks that the acknowledge persists and that the engine does not re-trigger.

// File: rtl/mirror_dma_pkg.sv
package mirror_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dmaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch start address, clear pointers
    logic issueRd;  // one array read this cycle
    logic push;     // array data arrives, write FIFO
    logic pop;      // write beat accepted, read FIFO
  } dmaStrb_t;

endpackage

// File: rtl/mirror_dma_ctrl.sv
module mirror_dma_ctrl
  import mirror_dma_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         copyReq,
  input  logic [CNT_W-1:0]             cfgWordsM1,
  input  logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  input  logic                         fifoEmpty,
  input  logic                         busReady,
  output dmaStrb_t                     strb,
  output logic                         busy,
  output logic                         copyAck,
  output logic                         busReq
);

  localparam int FCW = $clog2(DEPTH + 1);
  localparam int BW  = $clog2(BURST + 1);
  localparam logic [FCW:0]   OCC_LIM   = (FCW+1)'(DEPTH - BURST);
  localparam logic [CNT_W:0] BURST_LEN = (CNT_W+1)'(BURST);

  dmaState_t        state;
  logic [CNT_W:0]   rdLeft;
  logic [CNT_W:0]   wrLeft;
  logic [BW-1:0]    burstLeft;
  logic             pendQ;
  logic [FCW:0]     occ;
  logic [CNT_W:0]   burstLen;
  logic             run;
  logic             startBurst;

  assign run        = (state == ST_RUN);
  assign occ        = {1'b0, fifoCount} + {{FCW{1'b0}}, pendQ};
  assign burstLen   = (rdLeft < BURST_LEN) ? rdLeft : BURST_LEN;
  assign startBurst = run && (burstLeft == '0) && (rdLeft != '0) && (occ <= OCC_LIM);

  assign busReq       = run && !fifoEmpty;
  assign strb.load    = (state == ST_IDLE) && copyReq;
  assign strb.issueRd = run && ((burstLeft != '0) || startBurst);
  assign strb.push    = pendQ;
  assign strb.pop     = busReq && busReady;
  assign busy         = run;
  assign copyAck      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rdLeft    <= '0;
      wrLeft    <= '0;
      burstLeft <= '0;
      pendQ     <= 1'b0;
    end else begin
      pendQ <= strb.issueRd;
      if (strb.load) begin
        rdLeft    <= {1'b0, cfgWordsM1} + (CNT_W+1)'(1);
        wrLeft    <= {1'b0, cfgWordsM1} + (CNT_W+1)'(1);
        burstLeft <= '0;
      end else begin
        if (startBurst)        burstLeft <= BW'(burstLen - (CNT_W+1)'(1));
        else if (strb.issueRd) burstLeft <= burstLeft - BW'(1);
        if (strb.issueRd)      rdLeft    <= rdLeft - (CNT_W+1)'(1);
        if (strb.pop)          wrLeft    <= wrLeft - (CNT_W+1)'(1);
      end
      case (state)
        ST_IDLE: if (copyReq) state <= ST_RUN;
        ST_RUN:  if (strb.pop && (wrLeft == (CNT_W+1)'(1))) state <= ST_DONE;
        ST_DONE: if (!copyReq) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mirror_dma_dp.sv
module mirror_dma_dp
  import mirror_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int ARR_AW = 13,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dmaStrb_t                   strb,
  input  logic [ADDR_W-1:0]          cfgStartAddr,
  input  logic [DATA_W-1:0]          arrRdData,
  output logic [ARR_AW-1:0]          arrAddr,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [DATA_W-1:0]          busWData,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic                       fifoEmpty
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int FCW   = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  assign busWData  = mem[rdPtr];
  assign fifoEmpty = (fifoCount == '0);

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= arrRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      arrAddr   <= '0;
      busAddr   <= '0;
    end else if (strb.load) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      arrAddr   <= '0;
      busAddr   <= cfgStartAddr;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + PTR_W'(1);
      if (strb.pop) begin
        rdPtr   <= (rdPtr == LAST) ? '0 : rdPtr + PTR_W'(1);
        busAddr <= busAddr + ADDR_W'(4);
      end
      if (strb.issueRd) arrAddr <= arrAddr + ARR_AW'(1);
      case ({strb.push, strb.pop})
        2'b10:   fifoCount <= fifoCount + FCW'(1);
        2'b01:   fifoCount <= fifoCount - FCW'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

endmodule

// File: rtl/mirror_dma.sv
module mirror_dma
  import mirror_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int ARR_AW = 13,
  parameter int CNT_W  = 13,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              copyReq,
  output logic              copyAck,
  output logic              busy,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [CNT_W-1:0]  cfgWordsM1,
  output logic              arrRdEn,
  output logic [ARR_AW-1:0] arrAddr,
  input  logic [DATA_W-1:0] arrRdData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  input  logic              busReady
);

  localparam int FCW = $clog2(DEPTH + 1);

  dmaStrb_t       strb;
  logic [FCW-1:0] fifoCount;
  logic           fifoEmpty;

  assign arrRdEn = strb.issueRd;

  mirror_dma_ctrl #(.CNT_W(CNT_W), .DEPTH(DEPTH), .BURST(BURST)) i_ctrl (
    .clk(clk), .rstN(rstN), .copyReq(copyReq), .cfgWordsM1(cfgWordsM1),
    .fifoCount(fifoCount), .fifoEmpty(fifoEmpty), .busReady(busReady),
    .strb(strb), .busy(busy), .copyAck(copyAck), .busReq(busReq)
  );

  mirror_dma_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgStartAddr(cfgStartAddr),
    .arrRdData(arrRdData), .arrAddr(arrAddr), .busAddr(busAddr),
    .busWData(busWData), .fifoCount(fifoCount), .fifoEmpty(fifoEmpty)
  );

endmodule

// File: rtl/mirror_dma_chk.sv
module mirror_dma_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       copyReq,
  input logic                       copyAck,
  input logic                       busy,
  input logic                       arrRdEn,
  input logic                       busReq,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [DATA_W-1:0]          busWData,
  input logic                       busReady,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic                       push,
  input logic                       pop
);

  localparam int FCW = $clog2(DEPTH + 1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == FCW'(DEPTH)) |-> !(push && !pop)); // R5

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(copyReq)); // R2

  AST_DONE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> copyAck); // R8

  AST_BUSY_ACK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && copyAck)); // R8

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (copyAck && copyReq) |=> copyAck); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !arrRdEn)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busWData))); // R10

endmodule

bind mirror_dma mirror_dma_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .copyReq(copyReq), .copyAck(copyAck), .busy(busy),
  .arrRdEn(arrRdEn), .busReq(busReq), .busAddr(busAddr), .busWData(busWData),
  .busReady(busReady), .fifoCount(fifoCount), .push(strb.push), .pop(strb.pop)
);

// File: tb/test_mirror_dma.sv
module test_mirror_dma;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        copyReq = 1'b0;
  logic        copyAck, busy, arrRdEn, busReq;
  logic [31:0] cfgStartAddr = '0;
  logic [12:0] cfgWordsM1 = '0;
  logic [12:0] arrAddr;
  logic [31:0] arrRdData = '0;
  logic [31:0] busAddr, busWData;
  logic        busReady = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  int stallLeft = 0;
  bit usePattern = 1'b0;
  logic [7:0] lfsr = 8'hB5;

  // reference model state
  int mState = 0;            // 0 idle, 1 run, 2 done
  int nWords = 0, rdIdx = 0, wrIdx = 0;
  logic [31:0] mBase = '0;
  bit prevStall = 1'b0;
  logic [31:0] prevAddr = '0, prevData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mirror_dma i_mirror_dma (
    .clk(clk), .rstN(rstN), .copyReq(copyReq), .copyAck(copyAck), .busy(busy),
    .cfgStartAddr(cfgStartAddr), .cfgWordsM1(cfgWordsM1), .arrRdEn(arrRdEn),
    .arrAddr(arrAddr), .arrRdData(arrRdData), .busReq(busReq), .busAddr(busAddr),
    .busWData(busWData), .busReady(busReady)
  );

  function automatic logic [31:0] arrWord(int k);
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // array model: one cycle read latency
  always @(posedge clk) if (arrRdEn) arrRdData <= arrWord(int'(arrAddr));

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (stallLeft > 0) begin
      busReady  <= 1'b0;
      stallLeft <= stallLeft - 1;
    end else if (usePattern) busReady <= lfsr[0] | lfsr[2];
    else busReady <= 1'b1;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle reference compare, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk(!busy && !copyAck && !busReq && !arrRdEn, "R1", "outputs in reset",
          {busy, copyAck, busReq, arrRdEn}, 0);
      mState = 0;
    end else begin
      chk(busy == (mState == 1), "R2", "busy", busy, mState == 1);
      chk(copyAck == (mState == 2), "R8", "copyAck", copyAck, mState == 2);
      if (mState != 1)
        chk(!busReq && !arrRdEn, "R9", "activity outside copy", {busReq, arrRdEn}, 0);
      if (prevStall)
        chk(busReq && busAddr == prevAddr && busWData == prevData, "R10",
            "beat held under stall", busAddr, prevAddr);
      if (arrRdEn) begin
        chk(rdIdx < nWords, "R7", "read beyond count", rdIdx, nWords);
        chk(arrAddr == 13'(rdIdx), "R4", "array address", arrAddr, rdIdx);
        rdIdx++;
      end
      if (busReq && busReady) begin
        chk(wrIdx < nWords, "R3", "extra write beat", wrIdx, nWords);
        chk(busAddr == mBase + 32'(4 * wrIdx), "R4", "bus address", busAddr, mBase + 32'(4 * wrIdx));
        chk(busWData == arrWord(wrIdx), "R4", "bus data", busWData, arrWord(wrIdx));
        wrIdx++;
      end
      if (mState == 1)
        chk(rdIdx - wrIdx <= 8, "R5", "reads in flight over FIFO depth", rdIdx - wrIdx, 8);
      prevStall = busReq && !busReady;
      prevAddr  = busAddr;
      prevData  = busWData;
      case (mState)
        0: if (copyReq) begin
             mState = 1; nWords = int'(cfgWordsM1) + 1; mBase = cfgStartAddr;
             rdIdx = 0; wrIdx = 0;
           end
        1: if (wrIdx == nWords) begin
             chk(rdIdx == nWords, "R7", "total reads", rdIdx, nWords);
             mState = 2;
           end
        default: if (!copyReq) mState = 0;
      endcase
    end
  end

  task automatic runCopy(int m1, logic [31:0] base, int stall, bit pat, int holdAfter);
    int n = m1 + 1;
    int expRd = (n < 8) ? n : 8;
    int k;
    @(posedge clk); #2;
    cfgWordsM1 = 13'(m1);
    cfgStartAddr = base;
    usePattern = pat;
    stallLeft = stall;
    copyReq = 1'b1;
    if (stall > 0) begin
      repeat (stall - 4) @(negedge clk);
      chk(rdIdx == expRd, "R6", "reads while stalled", rdIdx, expRd);
    end
    k = 0;
    while (!copyAck) @(negedge clk);
    chk(wrIdx == n, "R3", "beats per copy", wrIdx, n);
    repeat (holdAfter) @(negedge clk);
    chk(copyAck && !busy, "R9", "ack held with request high", {copyAck, busy}, 2'b10);
    @(posedge clk); #2;
    copyReq = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!copyAck && !busy, "R9", "idle after request drop", {copyAck, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !copyAck && !busReq && !arrRdEn, "R1", "idle after reset",
        {busy, copyAck, busReq, arrRdEn}, 0);
    runCopy(0, 32'h2000_0000, 0, 1'b0, 2);        // single word, R3
    runCopy(9, 32'h2000_0100, 0, 1'b0, 0);        // short last burst, R7
    runCopy(13, 32'h2000_0400, 40, 1'b0, 1);      // stall: reads stop at 8, R6
    runCopy(5, 32'h2000_0800, 40, 1'b0, 0);       // stall: reads stop at 6, R6
    runCopy(20, 32'h2000_1000, 0, 1'b1, 10);      // irregular ready, held request, R5 R9
    runCopy(2, 32'h2000_2000, 0, 1'b1, 0);        // three words, R7
    runCopy(63, 32'h2000_3000, 0, 1'b1, 3);       // long copy, R4
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule